// File: doc/BRIEF.md
# Signed/Unsigned Multiply Unit With Product Shifter

This block is the multiply stage of a fixed-point datapath. A 16-bit operand
register (the hold register) captures one factor from the data bus when its load
strobe is raised. A multiply command brings the second factor and chooses
between two's-complement and unsigned arithmetic. The full 32-bit result is
written into a product register on the clock edge that samples the command.

The product register feeds an output shifter that drives the accumulator-side
path. A 2-bit mode selects one of four fixed settings: pass-through, left by
one, left by four, or arithmetic right by six. A left shift fills with zeros and
discards the bits moved out at the top. The shifter is purely combinational, so
a mode change appears on the output in the same cycle.

The reset is asynchronous and active-low. It is expected to be released in
step with the clock by the reset logic upstream.

Top module: `mpy_unit`

## Requirements
- R1: While `rst_n` is low, `hold_q`, `prod_q` and `alu_out` are all zero.
- R2: When `opnd_ld` is 1 at a rising edge, `hold_q` takes the value of `opnd_din` after that edge.
- R3: When `opnd_ld` is 0 at a rising edge, `hold_q` keeps its value, whatever `opnd_din` is.
- R4: When `mul_go` is 1 and `mul_signed` is 0 at a rising edge, `prod_q` becomes the unsigned 32-bit product of `hold_q` and `mul_din` after that edge.
- R5: When `mul_go` is 1 and `mul_signed` is 1 at a rising edge, `prod_q` becomes the two's-complement 32-bit product of `hold_q` and `mul_din` after that edge.
- R6: When `mul_go` is 0 at a rising edge, `prod_q` keeps its value, whatever `mul_din` and `mul_signed` are.
- R7: When `opnd_ld` and `mul_go` are both 1 at the same edge, the product uses the `hold_q` value from before that edge, and `hold_q` also loads the new operand.
- R8: `shf_mode` = 2'b00 makes `alu_out` equal to `prod_q`.
- R9: `shf_mode` = 2'b01 makes `alu_out` equal to `prod_q` shifted left by 1, with bit 0 set to zero and bit 31 dropped.
- R10: `shf_mode` = 2'b10 makes `alu_out` equal to `prod_q` shifted left by 4, with the low four bits set to zero.
- R11: `shf_mode` = 2'b11 makes `alu_out` equal to `prod_q` shifted right by 6, with bit 31 copied into the vacated upper six bits.
- R12: `alu_out` follows a change of `shf_mode` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_ld | input | 1 | Load strobe for the hold register |
| opnd_din | input | 16 | Operand from the data bus |
| mul_go | input | 1 | Multiply command |
| mul_signed | input | 1 | 1 = two's-complement multiply, 0 = unsigned |
| mul_din | input | 16 | Second factor, sampled with `mul_go` |
| shf_mode | input | 2 | Product shifter mode: 00 none, 01 left 1, 10 left 4, 11 right 6 |
| hold_q | output | 16 | Hold register contents |
| prod_q | output | 32 | Product register contents |
| alu_out | output | 32 | Shifted product sent to the accumulator path |

## Verification
Both `hold_q` and `prod_q` are due exactly one rising edge after the strobe or command that writes them. `alu_out` has no register and is due within the same cycle as a `shf_mode` or `prod_q` change. The bench drives every input on the falling edge. It reads the registers at the next falling edge, half a cycle after the edge that wrote them. It reads `alu_out` one nanosecond after it sets the mode. The sweep covers a grid of operand corners, both sign modes and all four shift modes. A pseudo-random run follows the same timing.

// File: rtl/mpy_pkg.sv
package mpy_pkg;
  typedef enum logic [1:0] {
    SHF_NONE = 2'b00,
    SHF_L1   = 2'b01,
    SHF_L4   = 2'b10,
    SHF_R6   = 2'b11
  } shf_mode_e;

  localparam int unsigned SHF_MODES = 4;
endpackage

// File: rtl/mpy_core.sv
module mpy_core #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sgn_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;

  logic signed [W:0]    a_ext;
  logic signed [W:0]    b_ext;
  logic signed [PW-1:0] p_full;

  // one extra bit per factor: sign copy in signed mode, zero otherwise
  always_comb begin
    a_ext  = $signed({sgn_i & a_i[W-1], a_i});
    b_ext  = $signed({sgn_i & b_i[W-1], b_i});
    p_full = a_ext * b_ext;
  end

  assign p_o = p_full;
endmodule

// File: rtl/mpy_prodshift.sv
module mpy_prodshift
  import mpy_pkg::*;
#(
  parameter int unsigned PW     = 32,
  parameter int unsigned SHL_LO = 1,
  parameter int unsigned SHL_HI = 4,
  parameter int unsigned SHR    = 6
) (
  input  logic [PW-1:0] p_i,
  input  logic [1:0]    mode_i,
  output logic [PW-1:0] y_o
);
  logic [PW-1:0] cand [SHF_MODES];

  for (genvar m = 0; m < SHF_MODES; m++) begin : g_cand
    if (m == int'(SHF_NONE)) begin : g_none
      assign cand[m] = p_i;
    end else if (m == int'(SHF_L1)) begin : g_l1
      assign cand[m] = p_i << SHL_LO;
    end else if (m == int'(SHF_L4)) begin : g_l4
      assign cand[m] = p_i << SHL_HI;
    end else begin : g_r6
      assign cand[m] = $unsigned($signed(p_i) >>> SHR);
    end
  end

  assign y_o = cand[mode_i];
endmodule

// File: rtl/mpy_unit.sv
module mpy_unit
  import mpy_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opnd_ld,
  input  logic [W-1:0]      opnd_din,
  input  logic              mul_go,
  input  logic              mul_signed,
  input  logic [W-1:0]      mul_din,
  input  logic [1:0]        shf_mode,
  output logic [W-1:0]      hold_q,
  output logic [2*W-1:0]    prod_q,
  output logic [2*W-1:0]    alu_out
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  hold_d;
  logic [PW-1:0] prod_d;
  logic [PW-1:0] mul_res;

  mpy_core #(.W(W)) u_core (
    .a_i   (hold_q),
    .b_i   (mul_din),
    .sgn_i (mul_signed),
    .p_o   (mul_res)
  );

  always_comb begin
    hold_d = opnd_din;
    prod_d = mul_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (opnd_ld) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (mul_go) begin
      prod_q <= prod_d;
    end
  end

  mpy_prodshift #(.PW(PW)) u_shf (
    .p_i    (prod_q),
    .mode_i (shf_mode),
    .y_o    (alu_out)
  );
endmodule

// File: rtl/mpy_unit_chk.sv
module mpy_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            opnd_ld,
  input logic [W-1:0]    opnd_din,
  input logic            mul_go,
  input logic            mul_signed,
  input logic [W-1:0]    mul_din,
  input logic [1:0]      shf_mode,
  input logic [W-1:0]    hold_q,
  input logic [2*W-1:0]  prod_q,
  input logic [2*W-1:0]  alu_out
);
  localparam int unsigned PW = 2 * W;

  p_rst_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (hold_q == '0 && prod_q == '0));

  p_hold_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_ld |=> hold_q == $past(opnd_din));

  p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !opnd_ld |=> $stable(hold_q));

  p_umul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_go && !mul_signed) |=>
      prod_q == PW'({{W{1'b0}}, $past(hold_q)} * {{W{1'b0}}, $past(mul_din)}));

  p_prod_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_go |=> $stable(prod_q));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shf_mode == 2'b00 |-> alu_out == prod_q);

  p_left1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shf_mode == 2'b01 |-> (alu_out[0] == 1'b0 && alu_out[PW-1:1] == prod_q[PW-2:0]));

  p_right6_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
    shf_mode == 2'b11 |-> alu_out[PW-1:PW-7] == {7{prod_q[PW-1]}});
endmodule

bind mpy_unit mpy_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opnd_ld    (opnd_ld),
  .opnd_din   (opnd_din),
  .mul_go     (mul_go),
  .mul_signed (mul_signed),
  .mul_din    (mul_din),
  .shf_mode   (shf_mode),
  .hold_q     (hold_q),
  .prod_q     (prod_q),
  .alu_out    (alu_out)
);

// File: tb/sim_mpy_unit.sv
`timescale 1ns/1ps
module sim_mpy_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        opnd_ld;
  logic [15:0] opnd_din;
  logic        mul_go;
  logic        mul_signed;
  logic [15:0] mul_din;
  logic [1:0]  shf_mode;
  logic [15:0] hold_q;
  logic [31:0] prod_q;
  logic [31:0] alu_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mpy_unit u0 (
    .clk(clk), .rst_n(rst_n), .opnd_ld(opnd_ld), .opnd_din(opnd_din),
    .mul_go(mul_go), .mul_signed(mul_signed), .mul_din(mul_din),
    .shf_mode(shf_mode), .hold_q(hold_q), .prod_q(prod_q), .alu_out(alu_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b, input bit s);
    if (s) return 32'($signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b}));
    return {16'h0, a} * {16'h0, b};
  endfunction

  function automatic logic [31:0] ref_shf(input logic [31:0] p, input logic [1:0] m);
    case (m)
      2'b00:   return p;
      2'b01:   return p * 32'd2;
      2'b10:   return p * 32'd16;
      default: return {{6{p[31]}}, p[31:6]};
    endcase
  endfunction

  task automatic run_mul(input logic [15:0] a, input logic [15:0] b, input bit s);
    logic [31:0] e;
    @(negedge clk); opnd_ld = 1'b1; opnd_din = a;
    @(negedge clk); opnd_ld = 1'b0; opnd_din = ~a;
    mul_go = 1'b1; mul_signed = s; mul_din = b;
    @(negedge clk); mul_go = 1'b0; mul_din = ~b; mul_signed = ~s;
    e = ref_mul(a, b, s);
    chk(s ? "R5 signed product" : "R4 unsigned product", prod_q, e);
    for (int m = 0; m < 4; m++) begin
      shf_mode = 2'(m);
      #1;
      case (m)
        0: chk("R8 no shift", alu_out, ref_shf(e, 2'b00));
        1: chk("R9 left 1", alu_out, ref_shf(e, 2'b01));
        2: chk("R10 left 4", alu_out, ref_shf(e, 2'b10));
        default: chk("R11 right 6", alu_out, ref_shf(e, 2'b11));
      endcase
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [8];
    logic [15:0] lfsr;
    logic [31:0] p_saved;
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'hFFFF; corners[5] = 16'h8001;
    corners[6] = 16'h00FF; corners[7] = 16'h5A3C;
    rst_n = 1'b0; opnd_ld = 1'b0; opnd_din = 16'hFFFF; mul_go = 1'b0;
    mul_signed = 1'b0; mul_din = 16'hFFFF; shf_mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 hold_q reset", {16'h0, hold_q}, 32'h0);
    chk("R1 prod_q reset", prod_q, 32'h0);
    chk("R1 alu_out reset", alu_out, 32'h0);
    rst_n = 1'b1;

    // R2 / R3: load then hold while the bus keeps changing
    @(negedge clk); opnd_ld = 1'b1; opnd_din = 16'hC3A5;
    @(negedge clk); opnd_ld = 1'b0;
    chk("R2 hold load", {16'h0, hold_q}, 32'h0000C3A5);
    for (int i = 0; i < 4; i++) begin
      opnd_din = 16'(i * 4099 + 17);
      @(negedge clk);
      chk("R3 hold keep", {16'h0, hold_q}, 32'h0000C3A5);
    end

    // R4/R5/R8..R11: corner grid, both sign modes
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_mul(corners[i], corners[j], bit'(s));

    // R6: product keeps while command is low
    run_mul(16'h1234, 16'h00F0, 1'b0);
    p_saved = prod_q;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); mul_din = 16'(i * 777); mul_signed = i[0];
      opnd_ld = 1'b1; opnd_din = 16'(i + 3);
      @(negedge clk); opnd_ld = 1'b0;
      chk("R6 prod keep", prod_q, p_saved);
    end

    // R7: load and multiply in the same cycle
    @(negedge clk); opnd_ld = 1'b1; opnd_din = 16'h0100;
    @(negedge clk); opnd_ld = 1'b1; opnd_din = 16'h0003;
    mul_go = 1'b1; mul_signed = 1'b0; mul_din = 16'h0005;
    @(negedge clk); opnd_ld = 1'b0; mul_go = 1'b0;
    chk("R7 product uses old operand", prod_q, 32'h00000500);
    chk("R7 hold loads new operand", {16'h0, hold_q}, 32'h00000003);

    // R12: mode change visible in the same cycle
    run_mul(16'h8000, 16'h0001, 1'b1);
    @(negedge clk); shf_mode = 2'b11;
    #2;
    chk("R12 same-cycle mode change", alu_out, 32'hFFFFFE00);
    shf_mode = 2'b10;
    #2;
    chk("R12 same-cycle mode change", alu_out, 32'hFFF80000);

    // random operands
    lfsr = 16'hACE1;
    for (int k = 0; k < 200; k++) begin
      logic [15:0] a;
      logic [15:0] b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr ^ 16'(k * 97);
      run_mul(a, b, bit'(k % 2));
    end

    // R1 again: reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0; shf_mode = 2'b01;
    #1;
    chk("R1 async clear prod", prod_q, 32'h0);
    chk("R1 async clear hold", {16'h0, hold_q}, 32'h0);
    chk("R1 async clear alu", alu_out, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule